// File: doc/BRIEF.md
# Five-Phase Instruction Sequencer with Wait Stall

This block drives the control timing of a small 32-bit core that keeps its operands in a single-port register RAM. Each instruction takes one pass through four phases, numbered 0 to 3. Phase 0 reads the source operand. Phase 1 reads the destination operand. Phase 2 executes the instruction and, in the same cycle, reads the next instruction word at the program counter. Phase 3 writes the result back. The RAM has one port, so the two operand reads and the write-back are serialized over it. Only the instruction fetch overlaps with execution.

A fifth phase, numbered 4, holds the core while a wait-type instruction runs, such as a counter-match wait or a pin-pattern wait. The core stays there until an external condition input reports the match. It then moves on to the write-back phase, so the wait instruction's result is still committed.

After reset the block makes one fetch-only pass to load the word at address 0. Normal execution starts after that pass. The ALU, the instruction set and the arbitration of shared memory are outside this block.

Top module: `insn_sequencer`

## Requirements
- R1: While reset is asserted and through the first pass after it, the outputs are as follows. `phase_o` starts at 0 and `pc_o` is 0. Phases 0 and 1 issue no read. Phase 2 reads address 0 with `exec_en_o` low. Phase 3 issues no write.
- R2: A non-stalling instruction steps the phase through 0, 1, 2, 3 and back to 0, one cycle per phase.
- R3: `rf_addr_o` carries the source field (bits AW-1:0) in phase 0. It carries the destination field (bits 2*AW-1:AW) in phases 1, 3 and 4. It carries `pc_o` in phase 2.
- R4: `rf_re_o` is high in phases 0 and 1 (outside the reset pass) and in phase 2. It is never high together with `rf_we_o`.
- R5: `exec_en_o` is high only in phase 2, and only when the condition passes. The 4-bit condition field (bits 24:21) passes when bit `{flag_c_i, flag_z_i}` of that field is set.
- R6: `pc_o` increments by one, wrapping at 2^AW, at the end of every phase 2. The word read in phase 2 becomes the current instruction at the end of the following phase 3.
- R7: An executing instruction whose opcode (bits 31:26) is 0x3E or 0x3F moves from phase 2 to phase 4. Phase 4 holds while `wait_done_i` is low, with no RAM strobe.
- R8: In phase 4, `wait_done_i` high moves the sequencer to phase 3 on the next edge.
- R9: A wait-type opcode whose condition fails does not stall. It goes from phase 2 straight to phase 3.
- R10: `rf_we_o` is high in phase 3 only when the write bit (bit 25) is set and the condition passed. Otherwise phase 3 still lasts exactly one cycle with no write.
- R11: The condition result used for write-back is the one taken at the end of phase 2. A flag change after phase 2 does not alter the phase-3 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rf_rdata_i | input | DW | Register RAM read data, valid the cycle after a read |
| flag_c_i | input | 1 | Carry flag for condition evaluation |
| flag_z_i | input | 1 | Zero flag for condition evaluation |
| wait_done_i | input | 1 | Wait condition met |
| phase_o | output | 3 | Current phase, 0 to 4 |
| pc_o | output | AW | Program counter |
| rf_addr_o | output | AW | Register RAM address |
| rf_re_o | output | 1 | Register RAM read strobe |
| rf_we_o | output | 1 | Register RAM write strobe (write-back enable) |
| exec_en_o | output | 1 | Execute enable for the datapath |

## Verification
A corrupted phase register shows up as a wrong `phase_o` and a wrong address-mux selection in the same cycle, so a single cycle of comparison exposes it. A fetched word latched at the wrong time does not appear until the next pass. It then shows as source and destination addresses in phases 0 and 1 that differ from the program word at the previous counter value, roughly four cycles later. A stale or missing condition latch only shows at a phase-3 write strobe, which is why the flags change every cycle in the stimulus.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    PH_SRC  = 3'd0,
    PH_DST  = 3'd1,
    PH_EXE  = 3'd2,
    PH_WB   = 3'd3,
    PH_WAIT = 3'd4
  } phase_e;

  localparam int OP_MSB  = 31;
  localparam int OP_LSB  = 26;
  localparam int WR_BIT  = 25;
  localparam int CND_MSB = 24;
  localparam int CND_LSB = 21;

  // opcodes 0x3E / 0x3F share this prefix
  localparam logic [4:0] WAIT_OP_PFX = 5'b11111;

  function automatic logic cond_pass(input logic [3:0] cnd, input logic c, input logic z);
    return cnd[{c, z}];
  endfunction
endpackage

// File: rtl/seq_phase_ctl.sv
module seq_phase_ctl
  import seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   exec_ok_i,
  input  logic   is_wait_i,
  input  logic   wait_done_i,
  output phase_e phase_o,
  output logic   boot_o,
  output logic   cond_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o  <= PH_SRC;
      boot_o   <= 1'b1;
      cond_q_o <= 1'b0;
    end else begin
      unique case (phase_o)
        PH_SRC: phase_o <= PH_DST;
        PH_DST: phase_o <= PH_EXE;
        PH_EXE: begin
          cond_q_o <= exec_ok_i;
          phase_o  <= (exec_ok_i && is_wait_i) ? PH_WAIT : PH_WB;
        end
        PH_WAIT: if (wait_done_i) phase_o <= PH_WB;
        default: begin
          phase_o <= PH_SRC;
          boot_o  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o
);
  logic          pend_q;
  logic [DW-1:0] hold_q;

  // fetched word lands the cycle after phase 2; keep it across a stall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= '0;
      pend_q <= 1'b0;
      hold_q <= '0;
      ir_o   <= '0;
    end else begin
      pend_q <= (phase_i == PH_EXE);
      if (pend_q) hold_q <= rdata_i;
      if (phase_i == PH_EXE) pc_o <= pc_o + 1'b1;
      if (phase_i == PH_WB) ir_o <= pend_q ? rdata_i : hold_q;
    end
  end
endmodule

// File: rtl/seq_rf_port.sv
module seq_rf_port
  import seq_pkg::*;
#(
  parameter int AW = 9
) (
  input  phase_e        phase_i,
  input  logic          boot_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] pc_i,
  input  logic          cond_ok_i,
  input  logic          cond_q_i,
  input  logic          wr_i,
  output logic [AW-1:0] addr_o,
  output logic          re_o,
  output logic          we_o,
  output logic          exec_o
);
  always_comb begin
    unique case (phase_i)
      PH_SRC:  addr_o = src_i;
      PH_EXE:  addr_o = pc_i;
      default: addr_o = dst_i;
    endcase
    re_o   = (((phase_i == PH_SRC) || (phase_i == PH_DST)) && !boot_i) || (phase_i == PH_EXE);
    we_o   = (phase_i == PH_WB) && !boot_i && wr_i && cond_q_i;
    exec_o = (phase_i == PH_EXE) && !boot_i && cond_ok_i;
  end
endmodule

// File: rtl/insn_sequencer.sv
module insn_sequencer
  import seq_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rf_rdata_i,
  input  logic          flag_c_i,
  input  logic          flag_z_i,
  input  logic          wait_done_i,
  output logic [2:0]    phase_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] rf_addr_o,
  output logic          rf_re_o,
  output logic          rf_we_o,
  output logic          exec_en_o
);
  localparam int SRC_LSB = 0;
  localparam int DST_LSB = AW;
  localparam int GAP_LSB = 2 * AW;

  phase_e        phase;
  logic          boot, cond_q, is_wait, cond_ok;
  logic [DW-1:0] ir;
  logic          unused_ir;

  assign is_wait   = (ir[OP_MSB:OP_LSB+1] == WAIT_OP_PFX);
  assign cond_ok   = cond_pass(ir[CND_MSB:CND_LSB], flag_c_i, flag_z_i);
  assign phase_o   = phase;
  assign unused_ir = ^ir[CND_LSB-1:GAP_LSB] ^ ir[OP_LSB];

  seq_phase_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_ok_i   (exec_en_o),
    .is_wait_i   (is_wait),
    .wait_done_i (wait_done_i),
    .phase_o     (phase),
    .boot_o      (boot),
    .cond_q_o    (cond_q)
  );

  seq_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .rdata_i (rf_rdata_i),
    .pc_o    (pc_o),
    .ir_o    (ir)
  );

  seq_rf_port #(.AW(AW)) u_port (
    .phase_i   (phase),
    .boot_i    (boot),
    .src_i     (ir[SRC_LSB+AW-1:SRC_LSB]),
    .dst_i     (ir[DST_LSB+AW-1:DST_LSB]),
    .pc_i      (pc_o),
    .cond_ok_i (cond_ok),
    .cond_q_i  (cond_q),
    .wr_i      (ir[WR_BIT]),
    .addr_o    (rf_addr_o),
    .re_o      (rf_re_o),
    .we_o      (rf_we_o),
    .exec_o    (exec_en_o)
  );
endmodule

// File: rtl/insn_sequencer_chk.sv
module insn_sequencer_chk #(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wait_done_i,
  input logic [2:0]    phase_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] rf_addr_o,
  input logic          rf_re_o,
  input logic          rf_we_o,
  input logic          exec_en_o
);
  p_step_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd0 |=> phase_o == 3'd1);
  p_step_dst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd1 |=> phase_o == 3'd2);
  p_step_wb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd3 |=> phase_o == 3'd0);
  p_fetch_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd2 |-> rf_addr_o == pc_o && rf_re_o);
  p_port_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_re_o && rf_we_o));
  p_exec_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_en_o |-> phase_o == 3'd2);
  p_pc_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd2 |=> pc_o == $past(pc_o) + 1'b1);
  p_pc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 3'd2 |=> $stable(pc_o));
  p_wait_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd4 && !wait_done_i |=> phase_o == 3'd4);
  p_wait_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd4 |-> !rf_re_o && !rf_we_o);
  p_wait_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd4 && wait_done_i |=> phase_o == 3'd3);
  p_no_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd2 && !exec_en_o |=> phase_o == 3'd3);
  p_we_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> phase_o == 3'd3);
  p_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= 3'd4);
endmodule

bind insn_sequencer insn_sequencer_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_insn_sequencer.sv
module sim_insn_sequencer;
  localparam int AW = 9;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] rdata;
  logic          fc, fz, wd;
  logic [2:0]    phase;
  logic [AW-1:0] pc, addr;
  logic          re, we, ex;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] lfsr;

  always #10 clk = ~clk;

  insn_sequencer #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rf_rdata_i(rdata),
    .flag_c_i(fc), .flag_z_i(fz), .wait_done_i(wd),
    .phase_o(phase), .pc_o(pc), .rf_addr_o(addr),
    .rf_re_o(re), .rf_we_o(we), .exec_en_o(ex)
  );

  function automatic logic [31:0] mk(int op, int wr, int cnd, int d, int s);
    logic [5:0] o = op[5:0];
    logic [3:0] c = cnd[3:0];
    logic [8:0] dd = d[8:0];
    logic [8:0] ss = s[8:0];
    return {o, wr[0], c, 3'b000, dd, ss};
  endfunction

  function automatic logic [31:0] prog(int a);
    case (a)
      0:  return mk(1, 1, 15, 20, 21);
      1:  return mk(2, 0, 15, 22, 23);
      2:  return mk(3, 1, 1, 24, 25);
      3:  return mk(62, 1, 15, 26, 27);
      4:  return mk(63, 1, 8, 28, 29);
      5:  return mk(62, 0, 0, 30, 31);
      6:  return mk(4, 1, 0, 32, 33);
      10: return mk(63, 1, 15, 34, 35);
      default: return mk(a % 31, a % 2, (a % 16) ^ 10, (a + 100) % DEPTH, (a + 200) % DEPTH);
    endcase
  endfunction

  // bench-side register RAM: synchronous read, output held when idle
  always @(posedge clk) if (re) rdata <= prog(int'(addr));

  // behavioural reference
  int          m_ph, m_pc, m_boot, m_condq;
  logic [31:0] m_ir, m_next;

  function automatic int m_cond();
    int idx = (fc ? 2 : 0) + (fz ? 1 : 0);
    return int'(m_ir[21 + idx]);
  endfunction
  function automatic int m_exec();
    return (m_ph == 2 && m_boot == 0 && m_cond() == 1) ? 1 : 0;
  endfunction
  function automatic int m_addr();
    if (m_ph == 0) return int'(m_ir[8:0]);
    if (m_ph == 2) return m_pc;
    return int'(m_ir[17:9]);
  endfunction
  function automatic int m_re();
    return (((m_ph == 0 || m_ph == 1) && m_boot == 0) || m_ph == 2) ? 1 : 0;
  endfunction
  function automatic int m_we();
    return (m_ph == 3 && m_boot == 0 && m_ir[25] && m_condq == 1) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_boot = 1; m_condq = 0; m_ir = '0; m_next = '0;
    end else begin
      case (m_ph)
        0: m_ph = 1;
        1: m_ph = 2;
        2: begin
          int ok;
          ok = m_exec();
          m_condq = ok;
          m_next = prog(m_pc);
          m_pc = (m_pc + 1) % DEPTH;
          m_ph = (ok == 1 && (m_ir[31:26] == 6'd62 || m_ir[31:26] == 6'd63)) ? 4 : 3;
        end
        3: begin m_ir = m_next; m_boot = 0; m_ph = 0; end
        default: if (wd) m_ph = 3;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 R7 R8 R9 phase", int'(phase), m_ph);
    chk("R6 pc", int'(pc), m_pc);
    chk("R3 addr", int'(addr), m_addr());
    chk("R4 re", int'(re), m_re());
    chk("R10 R11 we", int'(we), m_we());
    chk("R5 exec", int'(ex), m_exec());
  endtask

  task automatic drive();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fc = lfsr[3];
    fz = lfsr[5];
    wd = (lfsr[2:0] == 3'd0);
  endtask

  // fixed-value checks of the reset pass
  task automatic boot_pass();
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset pc", int'(pc), 0);
    chk("R1 reset re", int'(re), 0);
    chk("R1 reset we", int'(we), 0);
    rst_n = 1'b1;
    @(negedge clk); cyc++;
    chk("R1 boot m1 phase", int'(phase), 1);
    chk("R1 boot m1 re", int'(re), 0);
    @(negedge clk); cyc++;
    chk("R1 boot m2 phase", int'(phase), 2);
    chk("R1 boot m2 re", int'(re), 1);
    chk("R1 boot m2 addr", int'(addr), 0);
    chk("R1 boot m2 exec", int'(ex), 0);
    @(negedge clk); cyc++;
    chk("R1 boot m3 phase", int'(phase), 3);
    chk("R1 boot m3 we", int'(we), 0);
    chk("R6 boot pc", int'(pc), 1);
    @(negedge clk); cyc++;
    chk("R2 R6 first insn phase", int'(phase), 0);
    chk("R3 R6 first insn src", int'(addr), 21);
  endtask

  initial begin
    rst_n = 1'b0; fc = 1'b1; fz = 1'b1; wd = 1'b0; lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    boot_pass();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); cyc++;
      compare_all();
      drive();
    end
    rst_n = 1'b0; fc = 1'b1; fz = 1'b1; wd = 1'b0;
    @(negedge clk); cyc++;
    compare_all();
    boot_pass();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); cyc++;
      compare_all();
      drive();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cyc=%0d actual=running expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule